// File: doc/BRIEF.md
# Daisy-Chain Register Access Frame Node

This block sits at the receive end of a serial control link inside a device. It takes in a stream of link symbols, a start marker, payload bytes and an end marker, and gathers one fixed 10-byte request frame. It then checks the frame. When the frame is sound and addressed to this device, the block issues one 32-bit read or write on a simple request/acknowledge register bus. It then streams a 10-byte response back toward the transmit side. Line coding and serialization are handled elsewhere.

Several devices can share one link in a daisy chain, and each one holds a 4-bit index on a pin. A device that is not addressed by a frame still returns the frame, with its content unchanged, so the frame travels on to the next device. Every device ORs its own error bits into the footer of the frame. A non-zero footer at the end of the chain therefore reports that some device found a problem. Only one request is in flight at a time, so the link never needs back-pressure beyond the two stream handshakes.

Input symbols arrive on a valid/ready stream. A symbol moves when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the node is gathering a frame. The response leaves on a valid/ready stream. Once `out_valid` rises, the byte and its first/last flags are held until `out_ready` takes them, and the consumer may stall for as long as it likes.

Top module: `rab_frame_node`

## Requirements
- R1: `in_kind` encodes 0 = payload byte, 1 = start marker, 2 = end marker, 3 = no symbol (ignored). Payload bytes outside a frame are ignored. An end marker with no open frame is ignored and produces no response and no bus access. A start marker inside an open frame discards the bytes gathered so far and starts the frame again.
- R2: The header is byte 0. Header bits [2:0] are the version and must equal `VERSION`. Bit 3 = 1 selects a read. Bits [7:4] are the target index. A valid read addressed to `dev_idx` issues exactly one bus read at the address in bytes 1..4, most significant byte first. Response bytes 5..8 carry the read data, most significant byte first.
- R3: A valid write (header bit 3 = 0) addressed to `dev_idx` issues exactly one bus write. Its address comes from bytes 1..4 and its data from bytes 5..8, most significant byte first. The response echoes the write data in bytes 5..8.
- R4: Every response is 10 bytes. `out_first` is set only on byte 0 and `out_last` only on byte 9. Bytes 0..4 echo the header and address as received.
- R5: If the version field differs from `VERSION`, footer bit 1 is set and no bus access is made.
- R6: If address bits [1:0] are non-zero, footer bit 2 is set and no bus access is made.
- R7: A frame whose payload count is not 10 sets footer bit 3 only (bits 1 and 2 are not evaluated) and makes no bus access. Missing bytes are returned as zero, and bytes past the tenth are dropped.
- R8: A frame whose header index differs from `dev_idx` makes no bus access. It is returned with bytes 0..8 unchanged.
- R9: The response footer (byte 9) has bits [3:0] equal to the incoming footer bits [3:0] ORed with this node's error bits, and bits [7:4] equal to zero. Bit 0 is set when the bus acknowledges this node's access with `bus_err` high.
- R10: From the acceptance of the end marker until the last response byte is taken, `in_ready` is low. `bus_req` stays high, with address, direction and write data stable, until the cycle of `bus_ack`, and then drops.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_idx | input | 4 | This node's position index on the chain |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Node can take a symbol |
| in_kind | input | 2 | Symbol kind: 0 byte, 1 start, 2 end, 3 none |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte |
| out_first | output | 1 | Marks response byte 0 |
| out_last | output | 1 | Marks response byte 9 |
| bus_req | output | 1 | Register bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus completes the access this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |

## Verification
The bench builds the node with the default `VERSION` of 1, so headers whose low bits are 1 are accepted and any other code exercises the version error path. The chain position is a pin rather than a parameter. One build therefore drives index 3, index 15 and mismatching indices, which covers both the target path and the pass-through path. Frame lengths from 7 to 13 reach both the short and the long framing cases. Acknowledge delays of 0 to 3 cycles and a randomly stalling consumer exercise the hold rules on both handshakes.

// File: rtl/rab_pkg.sv
`timescale 1ns/1ps
package rab_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DEV_W     = 4;
  localparam int unsigned FRAME_LEN = 10;
  localparam int unsigned HDR_POS   = 0;
  localparam int unsigned ADDR_POS  = 1;
  localparam int unsigned DATA_POS  = 5;
  localparam int unsigned FOOT_POS  = 9;
  localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;

  // footer bit positions, fixed by the frame layout other nodes decode
  localparam int unsigned FB_BUS   = 0;
  localparam int unsigned FB_VER   = 1;
  localparam int unsigned FB_ALIGN = 2;
  localparam int unsigned FB_FRAME = 3;

  typedef enum logic [1:0] {
    SYM_DATA  = 2'd0,
    SYM_START = 2'd1,
    SYM_END   = 2'd2,
    SYM_NONE  = 2'd3
  } sym_e;

  typedef enum logic [1:0] {
    ST_RX  = 2'd0,
    ST_BUS = 2'd1,
    ST_TX  = 2'd2
  } node_st_e;
endpackage

// File: rtl/rab_collect.sv
`timescale 1ns/1ps
module rab_collect
  import rab_pkg::*;
#(
  parameter int unsigned LEN = FRAME_LEN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [1:0]            kind,
  input  logic [BYTE_W-1:0]     data,
  output logic [LEN*BYTE_W-1:0] bytes_o,
  output logic                  end_hit,
  output logic                  len_ok
);
  localparam int unsigned CW = $clog2(LEN + 2);

  logic [BYTE_W-1:0] slot [LEN];
  logic [CW-1:0]     cnt;
  logic              open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt    <= '0;
      for (int i = 0; i < int'(LEN); i++) slot[i] <= '0;
    end else if (take) begin
      unique case (sym_e'(kind))
        SYM_START: begin
          open_q <= 1'b1;
          cnt    <= '0;
          for (int i = 0; i < int'(LEN); i++) slot[i] <= '0;
        end
        SYM_DATA: begin
          if (open_q) begin
            if (cnt < CW'(LEN)) slot[cnt] <= data;
            if (cnt <= CW'(LEN)) cnt <= cnt + 1'b1;
          end
        end
        SYM_END:  open_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign end_hit = take && (sym_e'(kind) == SYM_END) && open_q;
  assign len_ok  = (cnt == CW'(LEN));

  for (genvar g = 0; g < int'(LEN); g++) begin : g_flat
    assign bytes_o[g*BYTE_W +: BYTE_W] = slot[g];
  end
endmodule

// File: rtl/rab_decode.sv
`timescale 1ns/1ps
module rab_decode
  import rab_pkg::*;
#(
  parameter int unsigned VERSION = 1
) (
  input  logic [BYTE_W-1:0] hdr,
  input  logic [WORD_W-1:0] addr,
  input  logic [DEV_W-1:0]  dev_idx,
  input  logic              len_ok,
  output logic              is_read,
  output logic              acc_go,
  output logic [3:0]        chk
);
  localparam logic [2:0] VER_CODE = 3'(VERSION);

  logic ver_bad, mis, match;

  always_comb begin
    ver_bad = (hdr[2:0] != VER_CODE);
    mis     = (addr[1:0] != 2'b00);
    match   = (hdr[7:4] == dev_idx);
    is_read = hdr[3];
    chk     = '0;
    if (!len_ok) begin
      chk[FB_FRAME] = 1'b1;
    end else begin
      chk[FB_VER]   = ver_bad;
      chk[FB_ALIGN] = mis;
    end
    acc_go = len_ok && !ver_bad && !mis && match;
  end
endmodule

// File: rtl/rab_emit.sv
`timescale 1ns/1ps
module rab_emit
  import rab_pkg::*;
#(
  parameter int unsigned LEN = FRAME_LEN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [LEN*BYTE_W-1:0] resp,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [BYTE_W-1:0]     out_data,
  output logic                  out_first,
  output logic                  out_last,
  output logic                  done
);
  localparam int unsigned IW = $clog2(LEN);

  logic [BYTE_W-1:0] lane [LEN];
  logic [IW-1:0]     idx;

  for (genvar g = 0; g < int'(LEN); g++) begin : g_lane
    assign lane[g] = resp[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (en && out_ready) begin
      idx <= out_last ? '0 : idx + 1'b1;
    end
  end

  assign out_valid = en;
  assign out_data  = lane[idx];
  assign out_first = (idx == '0);
  assign out_last  = (idx == IW'(LEN - 1));
  assign done      = en && out_ready && out_last;
endmodule

// File: rtl/rab_frame_node.sv
`timescale 1ns/1ps
module rab_frame_node
  import rab_pkg::*;
#(
  parameter int unsigned VERSION = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_idx,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int unsigned FB_W = FRAME_LEN * BYTE_W;

  node_st_e          state;
  logic [FB_W-1:0]   rx_bytes, resp;
  logic              take, end_hit, len_ok, is_read, acc_go, emit_done;
  logic [3:0]        chk, chk_q;
  logic              berr_q, swap_q;
  logic [WORD_W-1:0] rdata_q;
  logic [BYTE_W-1:0] hdr, foot_in, foot_out;

  assign in_ready = (state == ST_RX);
  assign take     = in_valid && in_ready;

  rab_collect #(.LEN(FRAME_LEN)) u_collect (
    .clk(clk), .rst_n(rst_n), .take(take), .kind(in_kind), .data(in_data),
    .bytes_o(rx_bytes), .end_hit(end_hit), .len_ok(len_ok)
  );

  assign hdr       = rx_bytes[HDR_POS*BYTE_W +: BYTE_W];
  assign foot_in   = rx_bytes[FOOT_POS*BYTE_W +: BYTE_W];
  for (genvar b = 0; b < int'(WORD_BYTES); b++) begin : g_word
    localparam int unsigned HI = (WORD_BYTES - 1 - b) * BYTE_W;
    assign bus_addr[HI +: BYTE_W]  = rx_bytes[(ADDR_POS + b)*BYTE_W +: BYTE_W];
    assign bus_wdata[HI +: BYTE_W] = rx_bytes[(DATA_POS + b)*BYTE_W +: BYTE_W];
  end

  rab_decode #(.VERSION(VERSION)) u_decode (
    .hdr(hdr), .addr(bus_addr), .dev_idx(dev_idx), .len_ok(len_ok),
    .is_read(is_read), .acc_go(acc_go), .chk(chk)
  );

  assign bus_req = (state == ST_BUS);
  assign bus_we  = !is_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_RX;
      chk_q   <= '0;
      berr_q  <= 1'b0;
      swap_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        ST_RX: if (end_hit) begin
          chk_q  <= chk;
          berr_q <= 1'b0;
          swap_q <= 1'b0;
          state  <= acc_go ? ST_BUS : ST_TX;
        end
        ST_BUS: if (bus_ack) begin
          rdata_q <= bus_rdata;
          berr_q  <= bus_err;
          swap_q  <= is_read;
          state   <= ST_TX;
        end
        ST_TX: if (emit_done) state <= ST_RX;
        default: state <= ST_RX;
      endcase
    end
  end

  assign foot_out = {foot_in[7:4] & 4'b0000,
                     foot_in[3:0] | chk_q | {3'b000, berr_q}};

  for (genvar k = 0; k < int'(FRAME_LEN); k++) begin : g_resp
    if (k == int'(FOOT_POS)) begin : g_foot
      assign resp[k*BYTE_W +: BYTE_W] = foot_out;
    end else if (k >= int'(DATA_POS) && k < int'(DATA_POS + WORD_BYTES)) begin : g_data
      localparam int unsigned HI = (DATA_POS + WORD_BYTES - 1 - k) * BYTE_W;
      assign resp[k*BYTE_W +: BYTE_W] =
        swap_q ? rdata_q[HI +: BYTE_W] : rx_bytes[k*BYTE_W +: BYTE_W];
    end else begin : g_echo
      assign resp[k*BYTE_W +: BYTE_W] = rx_bytes[k*BYTE_W +: BYTE_W];
    end
  end

  rab_emit #(.LEN(FRAME_LEN)) u_emit (
    .clk(clk), .rst_n(rst_n), .en(state == ST_TX), .resp(resp),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .done(emit_done)
  );
endmodule

// File: rtl/rab_frame_node_chk.sv
`timescale 1ns/1ps
module rab_frame_node_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_first,
  input logic        out_last,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || bus_req) |-> !in_ready);

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));

  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[1:0] == 2'b00);

  p_foot_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_data[7:4] == 4'h0);

  p_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_first && out_last));

  p_no_out_on_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !out_valid);
endmodule

bind rab_frame_node rab_frame_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_first(out_first),
  .out_last(out_last), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_rab_frame_node.sv
`timescale 1ns/1ps
module sim_rab_frame_node;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_idx = 4'd3;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd3;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_first, out_last;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = 32'h0;
  logic        bus_err = 1'b0;

  always #2.5 clk = ~clk;

  rab_frame_node u0 (
    .clk(clk), .rst_n(rst_n), .dev_idx(dev_idx), .in_valid(in_valid),
    .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int n_run = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- bus responder model ----
  logic [31:0] mem [64];
  bit          err_next = 0;
  int          ack_delay = 0, wait_cnt = 0, bus_cnt = 0;
  logic [31:0] seen_addr, seen_wdata;
  bit          seen_we, hold_ok = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      wait_cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wait_cnt == 0) begin
        seen_addr = bus_addr; seen_wdata = bus_wdata; seen_we = bus_we;
      end else if (bus_addr != seen_addr || bus_wdata != seen_wdata || bus_we != seen_we) begin
        hold_ok = 0;
      end
      if (wait_cnt >= ack_delay) begin
        bus_ack   = 1'b1;
        bus_rdata = mem[bus_addr[7:2]];
        bus_err   = err_next;
        if (bus_we && !err_next) mem[bus_addr[7:2]] = bus_wdata;
        bus_cnt++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // ---- frame stimulus and model ----
  logic [7:0] fb [16];
  int         fn;
  logic [7:0] exp_r [10];
  logic [7:0] got [10];
  bit         exp_acc;

  task automatic mk(input logic [7:0] hdr, input logic [31:0] addr,
                    input logic [31:0] wd, input logic [7:0] foot);
    fb[0] = hdr;
    for (int i = 0; i < 4; i++) begin
      fb[1+i] = addr[31-8*i -: 8];
      fb[5+i] = wd[31-8*i -: 8];
    end
    fb[9] = foot;
    for (int i = 10; i < 16; i++) fb[i] = 8'($urandom);
    fn = 10;
  endtask

  task automatic build_exp();
    logic [7:0] b [10];
    bit bad, ver, mis, match;
    logic [3:0] loc;
    logic [31:0] rd;
    for (int i = 0; i < 10; i++) b[i] = (i < fn) ? fb[i] : 8'h00;
    bad   = (fn != 10);
    ver   = (b[0][2:0] != 3'd1);
    mis   = (b[4][1:0] != 2'b00);
    match = (b[0][7:4] == dev_idx);
    loc   = bad ? 4'b1000 : {1'b0, mis, ver, 1'b0};
    exp_acc = !bad && !ver && !mis && match;
    rd = mem[b[4][7:2]];
    for (int i = 0; i < 9; i++) exp_r[i] = b[i];
    if (exp_acc && b[0][3])
      for (int i = 0; i < 4; i++) exp_r[5+i] = rd[31-8*i -: 8];
    exp_r[9] = {4'h0, b[9][3:0] | loc | {3'b000, exp_acc && err_next}};
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; in_kind = 2'd3;
  endtask

  task automatic collect(output bit ok_to);
    bit stalled = 0, r10_ok = 1, r11_ok = 1, fl_ok = 1;
    logic [7:0] prev = 8'h00;
    int i = 0, guard = 0;
    ok_to = 1;
    while (i < 10) begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      guard++;
      if (guard > 400) begin ok_to = 0; break; end
      if (out_valid) begin
        if (in_ready || bus_req) r10_ok = 0;
        if (stalled && out_data != prev) r11_ok = 0;
        if (out_ready) begin
          if (out_first != (i == 0) || out_last != (i == 9)) fl_ok = 0;
          got[i] = out_data; i++; stalled = 0;
        end else begin
          stalled = 1; prev = out_data;
        end
      end else if (stalled) begin
        r11_ok = 0;
      end
    end
    @(negedge clk); out_ready = 1'b0;
    check(r10_ok, "R10", "input held off while responding", {79'h0, r10_ok}, 80'h1);
    check(r11_ok, "R11", "response held under stall", {79'h0, r11_ok}, 80'h1);
    check(fl_ok, "R4", "first/last flags", {79'h0, fl_ok}, 80'h1);
  endtask

  task automatic run_frame(input string rtag, input string atag);
    int c0 = bus_cnt;
    bit to_ok;
    logic [79:0] a = '0, e = '0;
    build_exp();
    hold_ok = 1;
    put(2'd1, 8'h00);
    for (int i = 0; i < fn; i++) put(2'd0, fb[i]);
    put(2'd2, 8'h00);
    collect(to_ok);
    check(to_ok, rtag, "response arrived", {79'h0, to_ok}, 80'h1);
    for (int i = 0; i < 10; i++) begin
      a[79-8*i -: 8] = got[i];
      e[79-8*i -: 8] = exp_r[i];
    end
    check(a == e, rtag, "response bytes", a, e);
    check((bus_cnt - c0) == int'(exp_acc), atag, "bus access count",
          80'(bus_cnt - c0), 80'(exp_acc));
    if (exp_acc) begin
      logic [31:0] xa, xw;
      xa = {fb[1], fb[2], fb[3], fb[4]};
      xw = {fb[5], fb[6], fb[7], fb[8]};
      check(seen_addr == xa && seen_we == !fb[0][3] && (fb[0][3] || seen_wdata == xw),
            atag, "bus address/direction/data", {15'h0, seen_we, seen_addr, seen_wdata},
            {15'h0, !fb[0][3], xa, fb[0][3] ? seen_wdata : xw});
      check(hold_ok, "R10", "bus request held stable", {79'h0, hold_ok}, 80'h1);
    end
  endtask

  task automatic quiet(input string tag);
    bit ok = 1;
    int c0 = bus_cnt;
    repeat (20) begin
      @(negedge clk);
      if (out_valid || bus_req || !in_ready) ok = 0;
    end
    check(ok && bus_cnt == c0, tag, "ignored symbols left no trace", {79'h0, ok}, 80'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE0000 ^ (i * 32'h01010101);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !bus_req, "R10", "reset state",
          {77'h0, in_ready, out_valid, bus_req}, 80'h4);

    // R3 write then R2 read back
    dev_idx = 4'd3; ack_delay = 2; err_next = 0;
    mk(8'h31, 32'h0000_0010, 32'hA5A5_5A5A, 8'h00); run_frame("R3", "R3");
    mk(8'h39, 32'h0000_0010, 32'h1111_2222, 8'h00); run_frame("R2", "R2");
    check(exp_r[5] == 8'hA5 && exp_r[8] == 8'h5A, "R2", "read returns written word",
          {72'h0, exp_r[5]}, 80'hA5);
    // R5 version mismatch
    mk(8'h32, 32'h0000_0020, 32'h0, 8'h00); run_frame("R5", "R5");
    // R6 misaligned
    mk(8'h39, 32'h0000_0022, 32'h0, 8'h00); run_frame("R6", "R6");
    // R7 short and long
    mk(8'h31, 32'h0000_0030, 32'hDEAD_BEEF, 8'h00); fn = 7;  run_frame("R7", "R7");
    mk(8'h31, 32'h0000_0030, 32'hDEAD_BEEF, 8'h02); fn = 12; run_frame("R7", "R7");
    // R8 pass-through with footer kept, R9 high nibble cleared
    mk(8'h59, 32'h0000_0040, 32'h1234_5678, 8'h04); run_frame("R8", "R8");
    mk(8'h51, 32'h0000_0044, 32'h1234_5678, 8'hF1); run_frame("R9", "R8");
    // R9 bus error flagged
    err_next = 1; ack_delay = 0;
    mk(8'h39, 32'h0000_0048, 32'h0, 8'h00); run_frame("R9", "R2");
    err_next = 0;
    // R8 top index
    dev_idx = 4'd15;
    mk(8'hF1, 32'h0000_004C, 32'hCAFE_F00D, 8'h00); run_frame("R8", "R3");
    // R1 ignored symbols
    put(2'd0, 8'h77); put(2'd2, 8'h00); put(2'd3, 8'h55); quiet("R1");
    // R1 restart on second start marker
    mk(8'hF9, 32'h0000_004C, 32'h0, 8'h00);
    put(2'd1, 8'h00); put(2'd0, 8'h99); put(2'd0, 8'h98); put(2'd0, 8'h97);
    run_frame("R1", "R1");

    // random mix
    for (int t = 0; t < 250; t++) begin
      logic [3:0] idx;
      logic [7:0] hdr;
      logic [31:0] addr;
      dev_idx   = 4'($urandom);
      ack_delay = $urandom % 4;
      err_next  = (($urandom % 6) == 0);
      idx  = (($urandom % 5) < 3) ? dev_idx : 4'($urandom);
      hdr  = {idx, 1'($urandom), (($urandom % 5) != 0) ? 3'd1 : 3'($urandom)};
      addr = {24'($urandom), 6'($urandom), (($urandom % 7) != 0) ? 2'b00 : 2'($urandom)};
      mk(hdr, addr, $urandom, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
      if (($urandom % 7) == 0) fn = 7 + ($urandom % 7);
      run_frame("R4/R9", "R2/R3/R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule